// File: doc/BRIEF.md
# I2C Slave Address Recognition Front End

This block sits on the receive side of an I2C slave. It samples the SDA and SCL lines through synchronisers clocked by a faster system clock and finds START and STOP conditions. It shifts in each byte, classifies the address, and chooses what to put on SDA during the ninth clock. In hardware mode it matches the slave's own 7-bit or 10-bit address. It can also recognise the all-zero address: with R/W low this is a general call, and with R/W high it is a START byte.

A host steers the block through level inputs: the own address, a 10-bit select, a general-call enable, a software-decide mode and a NAK value. It also uses two strobes: one marks a write of the control word and one marks a read of the status word. In software-decide mode every received byte is handed to the host. The slave then holds SCL low in the acknowledge slot until the host's control write supplies the answer. Sticky status outputs report an address match, a general call, the direction bit and a filled receive byte. An interrupt line summarises them.

Top module: `i2c_addr_recog`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START, including a repeated one, clears `sam_o` and `gca_o` and begins a new address phase. After a STOP both `scl_oe_o` and `sda_oe_o` are 0.
- R2: With `ten_bit_i`=0 and `sw_ack_i`=0, an address byte whose bits [7:1] equal `own_addr_i[6:0]` is acknowledged. Acknowledging means SDA is pulled low during the ninth SCL high. The byte also sets `sam_o`.
- R3: With `ten_bit_i`=1, a first byte of 11110, then `own_addr_i[9:8]`, then R/W=0 is acknowledged without setting `sam_o`. A second byte equal to `own_addr_i[7:0]` is acknowledged and sets `sam_o`. Any other second byte is not acknowledged and leaves `sam_o` clear.
- R4: With `gc_en_i`=1 and `sw_ack_i`=0, the address byte 0x00 sets both `sam_o` and `gca_o`, in either address width. Its acknowledge slot follows `nak_i`: 0 pulls SDA low and 1 leaves SDA released. `gca_o` is never set without `sam_o`.
- R5: With `gc_en_i`=1, the address byte 0x01 (a START byte) sets `sam_o` and `gca_o` but is never acknowledged, whatever the value of `nak_i`.
- R6: With `gc_en_i`=0, the address byte 0x00 is not acknowledged and sets neither `sam_o` nor `gca_o` (the own address being nonzero).
- R7: `rw_o` takes bit 0 of every first address byte, in both hardware and software-decide modes. It is 0 after a general call and 1 after a START byte.
- R8: An address byte that matches nothing is not acknowledged. The data bytes that follow it until the next START are also not acknowledged and do not set `rdf_o`.
- R9: After a write-direction address match, each data byte appears on `rx_data_o` and sets `rdf_o`. Its acknowledge follows `nak_i` (0 = ACK). After a NAK the following bytes are ignored.
- R10: With `sw_ack_i`=1 at address time, hardware matching is off and `sam_o` and `gca_o` stay clear. Each byte goes to `rx_data_o` and sets `rdf_o`. After the byte's eighth clock, SCL is held low with SDA released until `ctl_wr_i` pulses. Then SDA is driven from the `nak_i` value present at that write (0 = ACK) and SCL is released.
- R11: Setting `sw_ack_i` after a general-call match makes each later data byte of that transfer wait for the host in the same way as R10.
- R12: `sam_o`, `gca_o` and `rdf_o` stay set until a `stat_rd_i` pulse clears them. `irq_o` is high whenever `sam_o` or `rdf_o` is high. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr_i | input | 10 | Own slave address; bits [6:0] used in 7-bit mode |
| ten_bit_i | input | 1 | 1 selects 10-bit own-address matching |
| gc_en_i | input | 1 | Enables general call / START byte recognition |
| sw_ack_i | input | 1 | Software-decide acknowledge mode |
| nak_i | input | 1 | Acknowledge value: 0 = ACK, 1 = NAK |
| ctl_wr_i | input | 1 | One-cycle strobe: host wrote the control word |
| stat_rd_i | input | 1 | One-cycle strobe: host read the status word |
| rx_data_o | output | 8 | Last byte handed to the host |
| sam_o | output | 1 | Slave address matched (sticky) |
| gca_o | output | 1 | General call or START byte seen (sticky) |
| rw_o | output | 1 | R/W bit of the last first address byte |
| rdf_o | output | 1 | Receive byte available (sticky) |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong transfer state or phase shows up on the bus within one byte. The master sees a missing or extra acknowledge in the ninth clock, or SCL stays low when it should be released. A bad address classification shows on `sam_o`, `gca_o` and `rw_o` a few system cycles after the eighth SCL rising edge of the address byte. The bench therefore checks every acknowledge bit as the master samples it, and reads the flags right after each byte. A stretch that leaks, or that fails to end, is caught while the master waits on SCL.

// File: rtl/i2c_ar_pkg.sv
package i2c_ar_pkg;

    localparam int OWN_W  = 10;
    localparam int BYTE_W = 8;
    localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR1,
        ST_ADDR2,
        ST_DATA,
        ST_SKIP
    } xfer_st_e;

    typedef enum logic [2:0] {
        PH_BITS,
        PH_PRE,
        PH_HOLD,
        PH_ACK,
        PH_ACK_HI
    } phase_e;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_OWN7,
        CL_HI10,
        CL_GCALL,
        CL_SBYTE
    } addr_cls_e;

    typedef struct packed {
        logic     drive_ack;
        logic     hold;
        xfer_st_e next_st;
    } ack_plan_t;

    typedef struct packed {
        logic sam;
        logic gca;
        logic rw;
        logic rdf;
    } flags_t;

    function automatic logic is_zero_addr(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:1] == '0;
    endfunction

endpackage

// File: rtl/i2c_ar_sync.sv
module i2c_ar_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic scl_d, sda_d, scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s    = scl_pipe[STAGES-1];
    assign sda_s    = sda_pipe[STAGES-1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_ar_shift.sv
module i2c_ar_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            shift_en,
    input  logic            din,
    output logic [BITS-1:0] byte_o,
    output logic            last_o
);
    localparam int CW = $clog2(BITS + 1);

    logic [BITS-1:0] sh;
    logic [CW-1:0]   cnt;

    assign byte_o = {sh[BITS-2:0], din};
    assign last_o = (cnt == CW'(BITS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh  <= '0;
            cnt <= '0;
        end else if (shift_en) begin
            sh  <= byte_o;
            cnt <= last_o ? '0 : cnt + CW'(1);
        end
    end

endmodule

// File: rtl/i2c_ar_decode.sv
module i2c_ar_decode
    import i2c_ar_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [OWN_W-1:0]  own_i,
    input  logic              ten_i,
    input  logic              gc_en_i,
    output addr_cls_e         cls_o,
    output logic              lo_match_o
);
    always_comb begin
        cls_o = CL_NONE;
        if (gc_en_i && is_zero_addr(byte_i)) begin
            cls_o = byte_i[0] ? CL_SBYTE : CL_GCALL;
        end else if (!ten_i && byte_i[7:1] == own_i[6:0]) begin
            cls_o = CL_OWN7;
        end else if (ten_i && byte_i[7:3] == TEN_BIT_PREFIX && byte_i[2:1] == own_i[9:8]) begin
            cls_o = CL_HI10;
        end
    end

    assign lo_match_o = (byte_i == own_i[7:0]);

endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog
    import i2c_ar_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe_o,
    output logic        sda_oe_o,
    input  logic [9:0]  own_addr_i,
    input  logic        ten_bit_i,
    input  logic        gc_en_i,
    input  logic        sw_ack_i,
    input  logic        nak_i,
    input  logic        ctl_wr_i,
    input  logic        stat_rd_i,
    output logic [7:0]  rx_data_o,
    output logic        sam_o,
    output logic        gca_o,
    output logic        rw_o,
    output logic        rdf_o,
    output logic        irq_o
);
    logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [BYTE_W-1:0] cur_byte;
    logic last_bit, shift_en, byte_done;
    addr_cls_e cls;
    logic lo_match;

    xfer_st_e  st;
    phase_e    ph;
    ack_plan_t plan, plan_q;
    flags_t    flg;
    logic      ack_drv;
    logic      set_sam, set_gca, set_rw, set_rdf;

    i2c_ar_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    assign shift_en  = scl_rise && (ph == PH_BITS) &&
                       (st == ST_ADDR1 || st == ST_ADDR2 || st == ST_DATA);
    assign byte_done = shift_en && last_bit;

    i2c_ar_shift #(.BITS(BYTE_W)) shift_i (
        .clk(clk), .rst(rst), .clr(start_ev | stop_ev), .shift_en(shift_en),
        .din(sda_s), .byte_o(cur_byte), .last_o(last_bit)
    );

    i2c_ar_decode dec_i (
        .byte_i(cur_byte), .own_i(own_addr_i), .ten_i(ten_bit_i),
        .gc_en_i(gc_en_i), .cls_o(cls), .lo_match_o(lo_match)
    );

    // Decide the answer for the byte that is completing.
    always_comb begin
        plan    = '{drive_ack: 1'b0, hold: 1'b0, next_st: ST_SKIP};
        set_sam = 1'b0;
        set_gca = 1'b0;
        set_rw  = 1'b0;
        set_rdf = 1'b0;
        unique case (st)
            ST_ADDR1: begin
                set_rw = 1'b1;
                if (sw_ack_i) begin
                    set_rdf   = 1'b1;
                    plan.hold = 1'b1;
                end else begin
                    unique case (cls)
                        CL_GCALL: begin
                            set_sam        = 1'b1;
                            set_gca        = 1'b1;
                            plan.drive_ack = ~nak_i;
                            plan.next_st   = nak_i ? ST_SKIP : ST_DATA;
                        end
                        CL_SBYTE: begin
                            set_sam = 1'b1;
                            set_gca = 1'b1;
                        end
                        CL_OWN7: begin
                            set_sam        = 1'b1;
                            plan.drive_ack = 1'b1;
                            plan.next_st   = cur_byte[0] ? ST_SKIP : ST_DATA;
                        end
                        CL_HI10: begin
                            plan.drive_ack = 1'b1;
                            plan.next_st   = cur_byte[0] ? ST_SKIP : ST_ADDR2;
                        end
                        default: ;
                    endcase
                end
            end
            ST_ADDR2: begin
                if (lo_match) begin
                    set_sam        = 1'b1;
                    plan.drive_ack = 1'b1;
                    plan.next_st   = ST_DATA;
                end
            end
            ST_DATA: begin
                set_rdf = 1'b1;
                if (sw_ack_i) begin
                    plan.hold = 1'b1;
                end else begin
                    plan.drive_ack = ~nak_i;
                    plan.next_st   = nak_i ? ST_SKIP : ST_DATA;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ph        <= PH_BITS;
            plan_q    <= '{drive_ack: 1'b0, hold: 1'b0, next_st: ST_IDLE};
            flg       <= '0;
            ack_drv   <= 1'b0;
            rx_data_o <= '0;
        end else begin
            if (stat_rd_i) begin
                flg.sam <= 1'b0;
                flg.gca <= 1'b0;
                flg.rdf <= 1'b0;
            end
            if (start_ev) begin
                st      <= ST_ADDR1;
                ph      <= PH_BITS;
                ack_drv <= 1'b0;
                flg.sam <= 1'b0;
                flg.gca <= 1'b0;
            end else if (stop_ev) begin
                st      <= ST_IDLE;
                ph      <= PH_BITS;
                ack_drv <= 1'b0;
            end else begin
                unique case (ph)
                    PH_BITS: begin
                        if (byte_done) begin
                            plan_q <= plan;
                            ph     <= PH_PRE;
                            if (set_sam) flg.sam <= 1'b1;
                            if (set_gca) flg.gca <= 1'b1;
                            if (set_rw)  flg.rw  <= cur_byte[0];
                            if (set_rdf) begin
                                flg.rdf   <= 1'b1;
                                rx_data_o <= cur_byte;
                            end
                        end
                    end
                    PH_PRE: begin
                        if (scl_fall) begin
                            ph      <= plan_q.hold ? PH_HOLD : PH_ACK;
                            ack_drv <= plan_q.hold ? 1'b0 : plan_q.drive_ack;
                        end
                    end
                    PH_HOLD: begin
                        if (ctl_wr_i) begin
                            ack_drv        <= ~nak_i;
                            plan_q.next_st <= nak_i ? ST_SKIP : ST_DATA;
                            ph             <= PH_ACK;
                        end
                    end
                    PH_ACK: begin
                        if (scl_rise) ph <= PH_ACK_HI;
                    end
                    PH_ACK_HI: begin
                        if (scl_fall) begin
                            ack_drv <= 1'b0;
                            st      <= plan_q.next_st;
                            ph      <= PH_BITS;
                        end
                    end
                    default: ph <= PH_BITS;
                endcase
            end
        end
    end

    assign scl_oe_o = (ph == PH_HOLD);
    assign sda_oe_o = ack_drv;
    assign sam_o    = flg.sam;
    assign gca_o    = flg.gca;
    assign rw_o     = flg.rw;
    assign rdf_o    = flg.rdf;
    assign irq_o    = flg.sam | flg.rdf;

    // R1: a STOP leaves both bus lines released
    a_r1_stop_release: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> (!scl_oe_o && !sda_oe_o));

    // R1: a START clears the per-transfer match flags
    a_r1_start_clears: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> (!sam_o && !gca_o));

    // R4: general call flag never stands alone
    a_r4_gca_implies_sam: assert property (@(posedge clk) disable iff (rst)
        gca_o |-> sam_o);

    // R10: a stretch ends only on a host write or a bus condition
    a_r10_hold_release: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_oe_o) |-> ($past(ctl_wr_i) || $past(start_ev) || $past(stop_ev)));

    // R10: SDA stays released while SCL is held
    a_r10_sda_free_in_hold: assert property (@(posedge clk) disable iff (rst)
        scl_oe_o |-> !sda_oe_o);

endmodule

// File: tb/i2c_addr_recog_tb_top.sv
`timescale 1ns/1ps
module i2c_addr_recog_tb_top;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_oe, sda_oe;
    logic scl_bus, sda_bus;
    logic [9:0] own_addr = 10'h02A;
    logic ten_bit = 1'b0, gc_en = 1'b0, sw_ack = 1'b0, nak = 1'b0;
    logic ctl_wr = 1'b0, stat_rd = 1'b0;
    logic [7:0] rx_data;
    logic sam, gca, rw, rdf, irq;

    assign scl_bus = m_scl & ~scl_oe;
    assign sda_bus = m_sda & ~sda_oe;

    int vectors = 0;
    int errors  = 0;

    i2c_addr_recog dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(own_addr),
        .ten_bit_i(ten_bit), .gc_en_i(gc_en), .sw_ack_i(sw_ack), .nak_i(nak),
        .ctl_wr_i(ctl_wr), .stat_rd_i(stat_rd), .rx_data_o(rx_data),
        .sam_o(sam), .gca_o(gca), .rw_o(rw), .rdf_o(rdf), .irq_o(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wait (scl_bus == 1'b1); @(negedge clk); wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic m_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wait (scl_bus == 1'b1); @(negedge clk); wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic m_write(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq();
            m_scl = 1'b1; wait (scl_bus == 1'b1); @(negedge clk); wq();
            m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wait (scl_bus == 1'b1); @(negedge clk); wq();
        acked = ~sda_bus;
        m_scl = 1'b0; wq();
    endtask

    task automatic host_read();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_answer(input logic nak_val, input logic [7:0] exp_rx, input string tag);
        wait (scl_oe == 1'b1);
        repeat (3 * Q) @(negedge clk);
        chk(scl_bus, 1'b0, {tag, " scl held"});
        chk(sda_oe, 1'b0, {tag, " sda free in hold"});
        chk(rdf, 1'b1, {tag, " rdf"});
        chk(rx_data, exp_rx, {tag, " rx_data"});
        nak = nak_val;
        ctl_wr = 1'b1;
        @(negedge clk) ctl_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk({sam, gca, rw, rdf, irq, scl_oe, sda_oe}, 7'd0, "R12 reset outputs");
    endtask

    task automatic t_own7();
        logic a;
        ten_bit = 0; gc_en = 0; sw_ack = 0; nak = 0;
        m_start(); m_write(8'h54, a);
        chk(a, 1, "R2 own addr ack");
        chk({sam, gca, rw}, 3'b100, "R2 sam/gca/rw");
        chk(irq, 1, "R12 irq on match");
        m_write(8'h5C, a);
        chk(a, 1, "R9 data ack");
        chk(rdf, 1, "R9 rdf");
        chk(rx_data, 8'h5C, "R9 rx_data");
        nak = 1;
        m_write(8'h33, a);
        chk(a, 0, "R9 data nak");
        chk(rx_data, 8'h33, "R9 rx_data nak byte");
        m_write(8'h44, a);
        chk(a, 0, "R9 ignored after nak");
        chk(rx_data, 8'h33, "R9 no load after nak");
        m_stop();
        chk({scl_oe, sda_oe}, 2'b00, "R1 stop releases");
        chk({sam, rdf}, 2'b11, "R12 sticky until read");
        host_read();
        chk({sam, gca, rdf, irq}, 4'd0, "R12 cleared by read");
        nak = 0;
    endtask

    task automatic t_miss();
        logic a;
        m_start(); m_write(8'h56, a);
        chk(a, 0, "R8 miss no ack");
        chk(sam, 0, "R8 miss sam");
        m_write(8'h11, a);
        chk(a, 0, "R8 data after miss no ack");
        chk(rdf, 0, "R8 data after miss rdf");
        m_stop();
    endtask

    task automatic t_gcall();
        logic a;
        gc_en = 1; nak = 0;
        m_start(); m_write(8'h00, a);
        chk(a, 1, "R4 gcall ack nak=0");
        chk({sam, gca, rw}, 3'b110, "R4 R7 gcall flags");
        m_start();
        chk({sam, gca}, 2'b00, "R1 repeated start clears");
        m_stop(); host_read();
        nak = 1;
        m_start(); m_write(8'h00, a);
        chk(a, 0, "R4 gcall nak=1");
        chk({sam, gca}, 2'b11, "R4 gcall flags nak=1");
        m_stop(); host_read();
        nak = 0;
        m_start(); m_write(8'h01, a);
        chk(a, 0, "R5 start byte never acked");
        chk({sam, gca, rw}, 3'b111, "R5 R7 start byte flags");
        m_stop(); host_read();
        gc_en = 0;
        m_start(); m_write(8'h00, a);
        chk(a, 0, "R6 gcall disabled no ack");
        chk({sam, gca}, 2'b00, "R6 gcall disabled flags");
        m_stop();
    endtask

    task automatic t_ten();
        logic a;
        ten_bit = 1; own_addr = 10'h2B5; nak = 0;
        m_start(); m_write(8'hF4, a);
        chk(a, 1, "R3 first byte ack");
        chk(sam, 0, "R3 no sam after first");
        m_write(8'hB5, a);
        chk(a, 1, "R3 second byte ack");
        chk(sam, 1, "R3 sam after second");
        m_write(8'h77, a);
        chk({a, rdf}, 2'b11, "R9 10-bit data");
        chk(rx_data, 8'h77, "R9 10-bit rx_data");
        m_stop(); host_read();
        m_start(); m_write(8'hF4, a); m_write(8'hB4, a);
        chk(a, 0, "R3 wrong low byte no ack");
        chk(sam, 0, "R3 wrong low byte sam");
        m_stop();
        gc_en = 1;
        m_start(); m_write(8'h00, a);
        chk(a, 1, "R4 gcall in 10-bit ack");
        chk({sam, gca}, 2'b11, "R4 gcall in 10-bit flags");
        m_stop(); host_read();
        ten_bit = 0; own_addr = 10'h02A; gc_en = 0;
    endtask

    task automatic t_sw();
        logic a;
        gc_en = 1; sw_ack = 1; nak = 1;
        m_start();
        fork
            m_write(8'h00, a);
            host_answer(1'b0, 8'h00, "R10 sw addr");
        join
        chk(a, 1, "R10 host ack written");
        chk({sam, gca, rw}, 3'b000, "R10 R7 no hw match flags");
        host_read();
        fork
            m_write(8'hC3, a);
            host_answer(1'b1, 8'hC3, "R10 sw data");
        join
        chk(a, 0, "R10 host nak written");
        m_stop();
        chk(scl_oe, 0, "R1 stop after sw");
        host_read();
        sw_ack = 0; nak = 0;
        m_start(); m_write(8'h00, a);
        chk({a, sam, gca}, 3'b111, "R11 gcall before sw");
        sw_ack = 1; nak = 1;
        fork
            m_write(8'hA5, a);
            host_answer(1'b0, 8'hA5, "R11 sw after gcall");
        join
        chk(a, 1, "R11 data acked by host");
        m_stop(); host_read();
        sw_ack = 0; gc_en = 0; nak = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_own7();
        t_miss();
        t_gcall();
        t_ten();
        t_sw();
        repeat (20) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule